// File: doc/BRIEF.md
# Interrupt Controller Command-Port Decoder

This block is the byte-wide register front end of a single eight-line interrupt controller. Software reaches it through a command address (address bit 0 low) and a data address (address bit 0 high), plus a separate select for the trigger-mode register. Command bytes are sorted into three groups: the start of an initialization sequence, a readback/poll/special-mask command, and an end-of-interrupt/priority command. The block holds the configuration that results and turns the priority commands into single-cycle strobes for an external priority core.

The priority core is not part of this block. It supplies its request and in-service vectors and its current winner. In return it receives the mask, the vector base, the mode flags, the trigger-mode bits and the strobes. Writes are single-cycle strobes. Read data is combinational from the current address and state. Neither side has back-pressure, so no valid/ready handshake is used: every access completes in the cycle it is presented. The bench never presents a read and a write in the same cycle.

Top module: `icp_cmd_port`

## Requirements
- R1: After reset the mask, vector base, trigger-mode bits and every mode flag are zero, all strobes are low, poll is disarmed, and a read at the command address returns the core's request vector.
- R2: A command write with bit 4 set starts initialization. It clears the mask, the special-mask flag and the readback select (back to request). It raises `stb_init` for the one cycle after the write. It records bit 0 as "fourth word needed". When bit 0 is clear it also clears the nested-mode and auto-EOI flags.
- R3: The first data write after initialization starts loads the vector base with the written value AND 0xF8. The second data write is consumed without changing any output. If no fourth word is needed, the data write after that loads the mask.
- R4: When a fourth word is needed, the third data write sets the nested-mode flag from bit 4 and the auto-EOI flag from bit 1. Later data writes load the mask.
- R5: Outside initialization, a data write loads the mask, and a read at the data address returns the mask.
- R6: A command write with bit 4 clear and bit 3 set is a readback/poll command. When its bit 1 is set, bit 0 chooses what the command address returns (1 = in-service, 0 = request). When bit 1 is clear, the choice is unchanged.
- R7: In a readback/poll command with bit 6 set, bit 5 becomes the special-mask flag. With bit 6 clear, the flag is unchanged.
- R8: A command write with bits 4 and 3 clear is a priority command whose code sits in bits 7:5. Codes 0 and 4 set the rotate-on-auto-EOI flag to bit 7. Code 2 changes no output.
- R9: In the cycle after the write, priority codes raise `stb_eoi` for one cycle. Code 1 raises it alone. Code 5 adds `stb_eoi_rotate`. Code 3 adds `stb_eoi_specific` with `stb_level` = bits 2:0. Code 7 adds both `stb_eoi_specific` and `stb_eoi_rotate`, again with `stb_level` = bits 2:0.
- R10: Priority code 6 raises `stb_setprio` for one cycle in the cycle after the write, with `stb_level` = bits 2:0.
- R11: A readback/poll command with bit 2 set arms poll. The next read (either address, trigger select low) then returns the core's winner index zero-extended and raises `stb_poll_clr` with `stb_poll_idx` = winner in that same cycle. If there is no winner, the read returns 7 and no clear is raised. Poll is disarmed afterwards.
- R12: A write with `bus_tm` high stores the data AND the parameter `TRIG_WMASK` (default 0xF8) in the trigger-mode register. A read with `bus_tm` high returns that register and leaves poll armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_tm | input | 1 | Selects the trigger-mode register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| core_irr | input | NLINES | Request vector from the priority core |
| core_isr | input | NLINES | In-service vector from the priority core |
| core_win_vld | input | 1 | Core has a winning request |
| core_win_idx | input | LW | Index of the winning line |
| ctl_mask | output | NLINES | Interrupt mask |
| ctl_vbase | output | 8 | Vector base (low three bits zero) |
| ctl_nested | output | 1 | Special fully nested mode |
| ctl_auto_eoi | output | 1 | Auto end-of-interrupt |
| ctl_rot_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| ctl_spec_mask | output | 1 | Special mask mode |
| ctl_trig | output | NLINES | Trigger-mode (level) bits |
| stb_init | output | 1 | Core: clear priority base, drop edge requests |
| stb_eoi | output | 1 | End-of-interrupt strobe |
| stb_eoi_specific | output | 1 | EOI names `stb_level` rather than the highest in service |
| stb_eoi_rotate | output | 1 | EOI also moves the priority base |
| stb_setprio | output | 1 | Set lowest priority to `stb_level` |
| stb_level | output | LW | Line number for specific EOI and set-priority |
| stb_poll_clr | output | 1 | Clear request and in-service of `stb_poll_idx` |
| stb_poll_idx | output | LW | Line consumed by a poll read |

## Verification
A sequencer that sits in the wrong state sends the next data byte to the wrong place. The mask or the vector base then disagrees at the ports on the clock after that write. A lost or stuck poll arm shows up on the very next read, as a wrong value and a wrong clear strobe in the same cycle. A mis-decoded priority code shows up as a wrong strobe set one cycle after the write. A reference model is compared against every output on every clock, so each of these errors is caught within one or two cycles of the access that triggers it.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [1:0] {
    SEQ_READY = 2'd0,
    SEQ_VBASE = 2'd1,
    SEQ_W3    = 2'd2,
    SEQ_W4    = 2'd3
  } seq_t;

  // priority-command code, bits 7:5 of the command byte
  typedef enum logic [2:0] {
    OP_ROT_OFF   = 3'd0,
    OP_EOI       = 3'd1,
    OP_NOP       = 3'd2,
    OP_EOI_SPEC  = 3'd3,
    OP_ROT_ON    = 3'd4,
    OP_EOI_ROT   = 3'd5,
    OP_SET_PRIO  = 3'd6,
    OP_EOI_SROT  = 3'd7
  } op2_t;

  localparam int BIT_START = 4;
  localparam int BIT_RDCMD = 3;
endpackage

// File: rtl/icp_init_seq.sv
module icp_init_seq
  import icp_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              data_wr,
  input  logic [7:0]        wdata,
  output logic [NLINES-1:0] mask_q,
  output logic [7:0]        vbase_q,
  output logic              nested_q,
  output logic              aeoi_q,
  output logic              init_q
);
  seq_t state_q;
  logic need4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_READY;
      need4_q  <= 1'b0;
      mask_q   <= '0;
      vbase_q  <= '0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      init_q   <= 1'b0;
    end else begin
      init_q <= 1'b0;
      if (start_wr) begin
        need4_q <= wdata[0];
        mask_q  <= '0;
        state_q <= SEQ_VBASE;
        init_q  <= 1'b1;
        if (!wdata[0]) begin
          nested_q <= 1'b0;
          aeoi_q   <= 1'b0;
        end
      end else if (data_wr) begin
        unique case (state_q)
          SEQ_READY: mask_q <= wdata[NLINES-1:0];
          SEQ_VBASE: begin
            vbase_q <= wdata & 8'hF8;
            state_q <= SEQ_W3;
          end
          SEQ_W3:    state_q <= need4_q ? SEQ_W4 : SEQ_READY;
          SEQ_W4: begin
            nested_q <= wdata[4];
            aeoi_q   <= wdata[1];
            state_q  <= SEQ_READY;
          end
          default:   state_q <= SEQ_READY;
        endcase
      end
    end
  end

  AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (mask_q == '0) && init_q);  // R2
  AST_VBASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_VBASE && data_wr && !start_wr) |=> state_q == SEQ_W3);  // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr && !start_wr) |=> $stable(mask_q));  // R5
endmodule

// File: rtl/icp_ocw_dec.sv
module icp_ocw_dec
  import icp_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic          rdcmd_wr,
  input  logic          prio_wr,
  input  logic          poll_take,
  input  logic [7:0]    wdata,
  output logic          rot_aeoi_q,
  output logic          smask_q,
  output logic          rd_isr_q,
  output logic          poll_q,
  output logic          eoi_q,
  output logic          eoi_spec_q,
  output logic          eoi_rot_q,
  output logic          setprio_q,
  output logic [LW-1:0] level_q
);
  op2_t op;
  assign op = op2_t'(wdata[7:5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_aeoi_q <= 1'b0;
      smask_q    <= 1'b0;
      rd_isr_q   <= 1'b0;
      poll_q     <= 1'b0;
      eoi_q      <= 1'b0;
      eoi_spec_q <= 1'b0;
      eoi_rot_q  <= 1'b0;
      setprio_q  <= 1'b0;
      level_q    <= '0;
    end else begin
      eoi_q      <= 1'b0;
      eoi_spec_q <= 1'b0;
      eoi_rot_q  <= 1'b0;
      setprio_q  <= 1'b0;
      if (start_wr) begin
        smask_q  <= 1'b0;
        rd_isr_q <= 1'b0;
      end
      if (rdcmd_wr) begin
        if (wdata[1]) rd_isr_q <= wdata[0];
        if (wdata[6]) smask_q  <= wdata[5];
      end
      if (rdcmd_wr && wdata[2]) poll_q <= 1'b1;
      else if (poll_take)       poll_q <= 1'b0;
      if (prio_wr) begin
        level_q <= wdata[LW-1:0];
        unique case (op)
          OP_ROT_OFF, OP_ROT_ON: rot_aeoi_q <= wdata[7];
          OP_EOI:      eoi_q <= 1'b1;
          OP_EOI_ROT:  begin eoi_q <= 1'b1; eoi_rot_q <= 1'b1; end
          OP_EOI_SPEC: begin eoi_q <= 1'b1; eoi_spec_q <= 1'b1; end
          OP_EOI_SROT: begin
            eoi_q <= 1'b1; eoi_spec_q <= 1'b1; eoi_rot_q <= 1'b1;
          end
          OP_SET_PRIO: setprio_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !rdcmd_wr) |=> !poll_q);  // R11
  AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_q |-> $past(prio_wr));  // R9
  AST_SETPRIO_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    setprio_q |-> $past(prio_wr) && !eoi_q);  // R10
endmodule

// File: rtl/icp_rd_mux.sv
module icp_rd_mux #(
  parameter int NLINES = 8,
  parameter int LW     = 3
) (
  input  logic              sel_tm,
  input  logic              sel_data,
  input  logic              poll,
  input  logic              rd_isr,
  input  logic [NLINES-1:0] trig,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] isr,
  input  logic              win_vld,
  input  logic [LW-1:0]     win_idx,
  output logic [7:0]        rdata
);
  localparam logic [7:0] NO_WINNER = 8'd7;

  always_comb begin
    if (sel_tm)        rdata = 8'(trig);
    else if (poll)     rdata = win_vld ? 8'(win_idx) : NO_WINNER;
    else if (sel_data) rdata = 8'(mask);
    else if (rd_isr)   rdata = 8'(isr);
    else               rdata = 8'(irr);
  end
endmodule

// File: rtl/icp_cmd_port.sv
module icp_cmd_port
  import icp_pkg::*;
#(
  parameter int         NLINES     = 8,
  parameter logic [7:0] TRIG_WMASK = 8'hF8,
  localparam int        LW         = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic              bus_tm,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NLINES-1:0] core_irr,
  input  logic [NLINES-1:0] core_isr,
  input  logic              core_win_vld,
  input  logic [LW-1:0]     core_win_idx,
  output logic [NLINES-1:0] ctl_mask,
  output logic [7:0]        ctl_vbase,
  output logic              ctl_nested,
  output logic              ctl_auto_eoi,
  output logic              ctl_rot_aeoi,
  output logic              ctl_spec_mask,
  output logic [NLINES-1:0] ctl_trig,
  output logic              stb_init,
  output logic              stb_eoi,
  output logic              stb_eoi_specific,
  output logic              stb_eoi_rotate,
  output logic              stb_setprio,
  output logic [LW-1:0]     stb_level,
  output logic              stb_poll_clr,
  output logic [LW-1:0]     stb_poll_idx
);
  logic cmd_wr, data_wr, start_wr, rdcmd_wr, prio_wr;
  logic poll_q, rd_isr_q, poll_take;
  logic [NLINES-1:0] trig_q;

  assign cmd_wr   = bus_wr && !bus_tm && !bus_addr;
  assign data_wr  = bus_wr && !bus_tm &&  bus_addr;
  assign start_wr = cmd_wr &&  bus_wdata[BIT_START];
  assign rdcmd_wr = cmd_wr && !bus_wdata[BIT_START] &&  bus_wdata[BIT_RDCMD];
  assign prio_wr  = cmd_wr && !bus_wdata[BIT_START] && !bus_wdata[BIT_RDCMD];

  assign poll_take    = bus_rd && !bus_tm && poll_q;
  assign stb_poll_clr = poll_take && core_win_vld;
  assign stb_poll_idx = core_win_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)                 trig_q <= '0;
    else if (bus_wr && bus_tm)  trig_q <= bus_wdata[NLINES-1:0] & TRIG_WMASK[NLINES-1:0];
  end
  assign ctl_trig = trig_q;

  icp_init_seq #(.NLINES(NLINES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .data_wr(data_wr),
    .wdata(bus_wdata), .mask_q(ctl_mask), .vbase_q(ctl_vbase),
    .nested_q(ctl_nested), .aeoi_q(ctl_auto_eoi), .init_q(stb_init)
  );

  icp_ocw_dec #(.LW(LW)) u_ocw (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .rdcmd_wr(rdcmd_wr),
    .prio_wr(prio_wr), .poll_take(poll_take), .wdata(bus_wdata),
    .rot_aeoi_q(ctl_rot_aeoi), .smask_q(ctl_spec_mask), .rd_isr_q(rd_isr_q),
    .poll_q(poll_q), .eoi_q(stb_eoi), .eoi_spec_q(stb_eoi_specific),
    .eoi_rot_q(stb_eoi_rotate), .setprio_q(stb_setprio), .level_q(stb_level)
  );

  icp_rd_mux #(.NLINES(NLINES), .LW(LW)) u_rd (
    .sel_tm(bus_tm), .sel_data(bus_addr), .poll(poll_q), .rd_isr(rd_isr_q),
    .trig(trig_q), .mask(ctl_mask), .irr(core_irr), .isr(core_isr),
    .win_vld(core_win_vld), .win_idx(core_win_idx), .rdata(bus_rdata)
  );

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_tm) |=> $stable(ctl_trig));  // R12
  AST_TM_READ_KEEPS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_q && bus_rd && bus_tm && !bus_wr) |=> poll_q);  // R12
endmodule

// File: tb/icp_cmd_port_test.sv
`timescale 1ns/1ps
module icp_cmd_port_test;
  localparam logic [7:0] WMASK = 8'hF8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0, bus_tm = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] core_irr = 0, core_isr = 0;
  logic core_win_vld = 0;
  logic [2:0] core_win_idx = 0;
  logic [7:0] ctl_mask, ctl_vbase, ctl_trig;
  logic ctl_nested, ctl_auto_eoi, ctl_rot_aeoi, ctl_spec_mask;
  logic stb_init, stb_eoi, stb_eoi_specific, stb_eoi_rotate, stb_setprio, stb_poll_clr;
  logic [2:0] stb_level, stb_poll_idx;

  always #2 clk = ~clk;

  icp_cmd_port uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_stage;   // 0 ready, 1 expects base, 2 word three, 3 word four
  bit m_need4, m_nested, m_aeoi, m_rot, m_smask, m_isrsel, m_poll;
  int m_mask, m_vbase, m_trig;
  bit e_init, e_eoi, e_spec, e_rotate, e_setp;
  int e_level;

  always @(posedge clk) begin
    int w;
    w = bus_wdata;
    e_init <= 0; e_eoi <= 0; e_spec <= 0; e_rotate <= 0; e_setp <= 0;
    if (!rst_n) begin
      m_stage <= 0; m_need4 <= 0; m_nested <= 0; m_aeoi <= 0; m_rot <= 0;
      m_smask <= 0; m_isrsel <= 0; m_poll <= 0; m_mask <= 0; m_vbase <= 0;
      m_trig <= 0; e_level <= 0;
    end else begin
      if (bus_wr && bus_tm) m_trig <= w & WMASK;
      if (bus_rd && !bus_tm && m_poll) m_poll <= 0;
      if (bus_wr && !bus_tm && !bus_addr) begin
        if (w[4]) begin
          m_need4 <= w[0]; m_mask <= 0; m_smask <= 0; m_isrsel <= 0;
          m_stage <= 1; e_init <= 1;
          if (!w[0]) begin m_nested <= 0; m_aeoi <= 0; end
        end else if (w[3]) begin
          if (w[2]) m_poll <= 1;
          if (w[1]) m_isrsel <= w[0];
          if (w[6]) m_smask <= w[5];
        end else begin
          e_level <= w % 8;
          case (w / 32)
            0: m_rot <= 0;
            4: m_rot <= 1;
            1: e_eoi <= 1;
            5: begin e_eoi <= 1; e_rotate <= 1; end
            3: begin e_eoi <= 1; e_spec <= 1; end
            7: begin e_eoi <= 1; e_spec <= 1; e_rotate <= 1; end
            6: e_setp <= 1;
            default: ;
          endcase
        end
      end
      if (bus_wr && !bus_tm && bus_addr) begin
        case (m_stage)
          0: m_mask <= w;
          1: begin m_vbase <= w & 8'hF8; m_stage <= 2; end
          2: m_stage <= m_need4 ? 3 : 0;
          default: begin m_nested <= w[4]; m_aeoi <= w[1]; m_stage <= 0; end
        endcase
      end
    end
  end

  function automatic int exp_rdata();
    if (bus_tm) return m_trig;
    if (m_poll) return core_win_vld ? int'(core_win_idx) : 7;
    if (bus_addr) return m_mask;
    return m_isrsel ? int'(core_isr) : int'(core_irr);
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5", "mask", ctl_mask, m_mask);
      chk("R3", "vbase", ctl_vbase, m_vbase);
      chk("R4", "nested", ctl_nested, m_nested);
      chk("R4", "auto_eoi", ctl_auto_eoi, m_aeoi);
      chk("R8", "rot_aeoi", ctl_rot_aeoi, m_rot);
      chk("R7", "spec_mask", ctl_spec_mask, m_smask);
      chk("R12", "trig", ctl_trig, m_trig);
      chk("R2", "stb_init", stb_init, e_init);
      chk("R9", "stb_eoi", stb_eoi, e_eoi);
      chk("R9", "stb_eoi_specific", stb_eoi_specific, e_spec);
      chk("R9", "stb_eoi_rotate", stb_eoi_rotate, e_rotate);
      chk("R10", "stb_setprio", stb_setprio, e_setp);
      if (e_setp || e_spec) chk("R10", "stb_level", stb_level, e_level);
      chk("R11", "stb_poll_clr", stb_poll_clr,
          int'(bus_rd && !bus_tm && m_poll && core_win_vld));
      if (stb_poll_clr) chk("R11", "stb_poll_idx", stb_poll_idx, core_win_idx);
      if (bus_rd) chk("R6", "rdata", bus_rdata, exp_rdata());
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input bit wr, input bit tm, input bit a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_tm = tm; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_tm = 0;
  endtask

  task automatic rd_now(input bit tm, input bit a, input string tag, input int exp);
    @(negedge clk);
    bus_rd = 1; bus_tm = tm; bus_addr = a;
    #1 chk(tag, "directed read", bus_rdata, exp);
    @(negedge clk);
    bus_rd = 0; bus_tm = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    core_irr = 8'h5A; core_isr = 8'h81;
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", "mask after reset", ctl_mask, 0);
    chk("R1", "vbase after reset", ctl_vbase, 0);
    chk("R1", "strobes after reset",
        {stb_init, stb_eoi, stb_setprio, stb_poll_clr}, 0);
    rd_now(0, 0, "R1", 8'h5A);
    // R5 mask load outside initialization
    acc(1, 0, 1, 8'h3C);
    rd_now(0, 1, "R5", 8'h3C);
    // R2 R3 R4: sequence with fourth word
    acc(1, 0, 0, 8'h11);
    acc(1, 0, 1, 8'h25);
    acc(1, 0, 1, 8'h04);
    acc(1, 0, 1, 8'h12);
    chk("R4", "nested after word4", ctl_nested, 1);
    chk("R3", "vbase", ctl_vbase, 8'h20);
    acc(1, 0, 1, 8'hA5);
    rd_now(0, 1, "R4", 8'hA5);
    // R6 R7 set state that the next start must clear
    acc(1, 0, 0, 8'h0B);
    rd_now(0, 0, "R6", 8'h81);
    acc(1, 0, 0, 8'h68);
    chk("R7", "special mask set", ctl_spec_mask, 1);
    // R2 R3 sequence without fourth word
    acc(1, 0, 0, 8'h10);
    chk("R2", "nested cleared", ctl_nested, 0);
    chk("R2", "special mask cleared", ctl_spec_mask, 0);
    rd_now(0, 0, "R2", 8'h5A);
    acc(1, 0, 1, 8'h47);
    acc(1, 0, 1, 8'hFF);
    acc(1, 0, 1, 8'h99);
    rd_now(0, 1, "R3", 8'h99);
    chk("R3", "vbase aligned", ctl_vbase, 8'h40);
    // R6 R7 readback select and special mask rules
    acc(1, 0, 0, 8'h0B);
    acc(1, 0, 0, 8'h08);
    rd_now(0, 0, "R6", 8'h81);
    acc(1, 0, 0, 8'h0A);
    rd_now(0, 0, "R6", 8'h5A);
    acc(1, 0, 0, 8'h68);
    acc(1, 0, 0, 8'h28);
    chk("R7", "bit6 clear keeps flag", ctl_spec_mask, 1);
    acc(1, 0, 0, 8'h48);
    chk("R7", "special mask off", ctl_spec_mask, 0);
    // R8 R9 R10 priority codes
    acc(1, 0, 0, 8'h80);
    chk("R8", "rotate flag on", ctl_rot_aeoi, 1);
    acc(1, 0, 0, 8'h40);
    chk("R8", "nop keeps flag", ctl_rot_aeoi, 1);
    acc(1, 0, 0, 8'h00);
    acc(1, 0, 0, 8'h20);
    acc(1, 0, 0, 8'hA0);
    acc(1, 0, 0, 8'h63);
    acc(1, 0, 0, 8'hE6);
    acc(1, 0, 0, 8'hC5);
    acc(1, 0, 0, 8'hC2);
    // R11 poll with a winner
    acc(1, 0, 0, 8'h0C);
    core_win_vld = 1; core_win_idx = 3'd5;
    rd_now(0, 1, "R11", 5);
    rd_now(0, 1, "R11", 8'h99);
    // R11 poll without a winner
    acc(1, 0, 0, 8'h0C);
    core_win_vld = 0;
    rd_now(0, 0, "R11", 7);
    rd_now(0, 0, "R11", 8'h5A);
    // R12 trigger-mode register and poll survival
    acc(1, 1, 0, 8'hFF);
    rd_now(1, 0, "R12", 8'hF8);
    acc(1, 0, 0, 8'h0C);
    core_win_vld = 1; core_win_idx = 3'd2;
    rd_now(1, 1, "R12", 8'hF8);
    rd_now(0, 0, "R12", 2);
    acc(1, 1, 1, 8'h27);
    rd_now(1, 1, "R12", 8'h20);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule